// File: doc/BRIEF.md
# Branch-Exchange Fetch Sequencer

This block drives the instruction-fetch side of the memory interface while a branch that may also switch instruction-set state is carried out. The processor has two states. In the wide state instructions are 4 bytes long. In the compact state they are 2 bytes long. When the block is started, it runs a fixed run of three fetch cycles. The first cycle still belongs to the old state. The second and third cycles refill the pipeline from the branch target under the new state.

The target comes in as a value from the ALU. Bit 0 of the target chooses the new state. The target is then aligned to the new instruction width before it is used. When the run is over, the block hands the next sequential fetch address to the following fetch logic. Register reads and arithmetic are outside this block. The current PC, the target and the current state bit reach it as plain inputs.

Top module: `bx_fetch_seq`

## Requirements
- R1: After reset the block is idle with these outputs: `mreq_o`=0, `opfetch_o`=0, `seq_o`=0, `done_o`=0, `state_o`=0, `addr_o`=0 and `next_addr_o`=0.
- R2: A `start_i` seen at a clock edge while idle makes the next cycle the first fetch cycle. In that cycle `addr_o` = `pc_i` + 2×(old width) and `seq_o`=0. `size_o` and `state_o` take the old-state values. The widths are 4 and 2. The size code is 2 for wide and 1 for compact. The state bit is 0 for wide and 1 for compact.
- R3: In the second cycle `addr_o` is the aligned target and `seq_o`=1. `size_o` and `state_o` take the new-state values.
- R4: In the third cycle `addr_o` = aligned target + new width, `seq_o`=1, the new-state settings stay in force and `done_o`=1. `done_o` is 1 in no other cycle.
- R5: While `done_o`=1, `next_addr_o` = aligned target + 2×(new width). It holds that value until the next run.
- R6: In all three cycles `mreq_o`=1, `opfetch_o`=1 and `write_o`=0 (a read). While idle, `mreq_o`=0 and `opfetch_o`=0.
- R7: Bit 0 of `target_i` selects the new state (1 means compact). The aligned target clears bit 0 in the compact state and bits 1:0 in the wide state.
- R8: A `start_i` that arrives during any of the three cycles is ignored. This includes the third cycle. Exactly three request cycles appear per accepted start, and their values come from the accepted start only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a run when the block is idle |
| cur_state_i | input | 1 | Current state bit (0 wide, 1 compact) |
| pc_i | input | ADDR_W | Current PC |
| target_i | input | ADDR_W | Branch target from the ALU; bit 0 gives the new state |
| addr_o | output | ADDR_W | Fetch address |
| size_o | output | 2 | Access-size code (2 word, 1 halfword) |
| write_o | output | 1 | 1 for a write; always 0 in this block |
| mreq_o | output | 1 | Memory request, active high |
| seq_o | output | 1 | Address follows the previous one |
| opfetch_o | output | 1 | Access is an instruction fetch |
| state_o | output | 1 | State bit in force for this access |
| done_o | output | 1 | High in the last fetch cycle |
| next_addr_o | output | ADDR_W | Next sequential fetch address after the run |

## Verification
The alignment assertion on the first-cycle address takes for granted that `pc_i` is aligned to the width of the current state. Every PC the stimulus applies is a multiple of 4 in the wide state and a multiple of 2 in the compact state. The target needs no such care, because the block aligns it itself. The stimulus therefore feeds targets with both low bits in every combination. It also holds `start_i` high across a whole run and into its last cycle, which tests that a start is ignored while the block is busy.

// File: rtl/bx_seq_pkg.sv
package bx_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_FETCH   = 2'd1,
        PH_REFILL1 = 2'd2,
        PH_REFILL2 = 2'd3
    } phase_e;

    localparam logic [1:0] SIZE_WORD = 2'd2;
    localparam logic [1:0] SIZE_HALF = 2'd1;

endpackage

// File: rtl/bx_isa_decode.sv
module bx_isa_decode #(
    parameter int ADDR_W = 32
) (
    input  logic              state_i,
    output logic [ADDR_W-1:0] width_o,
    output logic [1:0]        size_o
);
    import bx_seq_pkg::*;

    always_comb begin
        width_o = state_i ? ADDR_W'(2) : ADDR_W'(4);
        size_o  = state_i ? SIZE_HALF : SIZE_WORD;
    end
endmodule

// File: rtl/bx_tgt_align.sv
module bx_tgt_align #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] aligned_o,
    output logic              new_state_o
);
    localparam logic [ADDR_W-1:0] MASK_HALF = ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] MASK_WORD = ~ADDR_W'(3);

    always_comb begin
        new_state_o = target_i[0];
        aligned_o   = target_i & (target_i[0] ? MASK_HALF : MASK_WORD);
    end
endmodule

// File: rtl/bx_fetch_seq.sv
module bx_fetch_seq #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cur_state_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        size_o,
    output logic              write_o,
    output logic              mreq_o,
    output logic              seq_o,
    output logic              opfetch_o,
    output logic              state_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] next_addr_o
);
    import bx_seq_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic              mreq;
        logic              seq;
        logic              opf;
        logic              st;
        logic              done;
        logic [ADDR_W-1:0] tgt;
        logic              nst;
        logic [ADDR_W-1:0] nxt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [ADDR_W-1:0] old_width, new_width, tgt_aligned;
    logic [1:0]        old_size, new_size;
    logic              tgt_state;

    bx_isa_decode #(.ADDR_W(ADDR_W)) u_old_dec (
        .state_i (cur_state_i),
        .width_o (old_width),
        .size_o  (old_size)
    );

    bx_isa_decode #(.ADDR_W(ADDR_W)) u_new_dec (
        .state_i (r_q.nst),
        .width_o (new_width),
        .size_o  (new_size)
    );

    bx_tgt_align #(.ADDR_W(ADDR_W)) u_align (
        .target_i    (target_i),
        .aligned_o   (tgt_aligned),
        .new_state_o (tgt_state)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                r_d.mreq = 1'b0;
                r_d.opf  = 1'b0;
                r_d.seq  = 1'b0;
                if (start_i) begin
                    r_d.phase = PH_FETCH;
                    r_d.addr  = pc_i + (old_width << 1);
                    r_d.size  = old_size;
                    r_d.st    = cur_state_i;
                    r_d.mreq  = 1'b1;
                    r_d.opf   = 1'b1;
                    r_d.tgt   = tgt_aligned;
                    r_d.nst   = tgt_state;
                end
            end
            PH_FETCH: begin
                r_d.phase = PH_REFILL1;
                r_d.addr  = r_q.tgt;
                r_d.size  = new_size;
                r_d.st    = r_q.nst;
                r_d.seq   = 1'b1;
            end
            PH_REFILL1: begin
                r_d.phase = PH_REFILL2;
                r_d.addr  = r_q.tgt + new_width;
                r_d.nxt   = r_q.tgt + (new_width << 1);
                r_d.done  = 1'b1;
            end
            default: begin
                r_d.phase = PH_IDLE;
                r_d.mreq  = 1'b0;
                r_d.opf   = 1'b0;
                r_d.seq   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_o      = r_q.addr;
    assign size_o      = r_q.size;
    assign write_o     = 1'b0;
    assign mreq_o      = r_q.mreq;
    assign seq_o       = r_q.seq;
    assign opfetch_o   = r_q.opf;
    assign state_o     = r_q.st;
    assign done_o      = r_q.done;
    assign next_addr_o = r_q.nxt;

    // R8: one accepted start gives exactly three request cycles
    a_r8_three_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mreq_o) |=> mreq_o ##1 mreq_o ##1 !mreq_o);

    // R3: the non-sequential first cycle is followed by a sequential refill
    a_r3_refill_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_o && !seq_o) |=> (mreq_o && seq_o && !done_o));

    // R4: done comes only in a sequential request cycle after another request
    a_r4_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mreq_o && seq_o && $past(mreq_o) && $past(seq_o)));

    // R5: handoff address is one width past the last fetch
    a_r5_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (next_addr_o == addr_o + (state_o ? ADDR_W'(2) : ADDR_W'(4))));

    // R7: fetch addresses are aligned to the width in force
    a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_o |-> (state_o ? (addr_o[0] == 1'b0) : (addr_o[1:0] == 2'b00)));

    // R2: access-size code matches the state bit on every request
    a_r2_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_o |-> (size_o == (state_o ? SIZE_HALF : SIZE_WORD)));

    // R6: an instruction fetch is flagged exactly when memory is requested
    a_r6_fetch_flag: assert property (@(posedge clk) disable iff (!rst_n)
        opfetch_o == mreq_o);
endmodule

// File: tb/bx_fetch_seq_bench.sv
module bx_fetch_seq_bench;
    localparam int AW = 32;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [1:0]    size;
        logic          st;
        logic          seq;
        logic          done;
        logic [AW-1:0] nxt;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          cur_state_i = 1'b0;
    logic [AW-1:0] pc_i = '0;
    logic [AW-1:0] target_i = '0;
    logic [AW-1:0] addr_o, next_addr_o;
    logic [1:0]    size_o;
    logic          write_o, mreq_o, seq_o, opfetch_o, state_o, done_o;

    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;
    bit   mon_on = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    bx_fetch_seq #(.ADDR_W(AW)) u_bx_fetch_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cur_state_i(cur_state_i),
        .pc_i(pc_i), .target_i(target_i), .addr_o(addr_o), .size_o(size_o),
        .write_o(write_o), .mreq_o(mreq_o), .seq_o(seq_o), .opfetch_o(opfetch_o),
        .state_o(state_o), .done_o(done_o), .next_addr_o(next_addr_o)
    );

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: launch a run, hold start for hold cycles, push expected items
    task automatic run_bx(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                          input logic cur, input int hold);
        logic [AW-1:0] ow, nw, al;
        logic          ns;
        exp_t          e;
        ow = cur ? 2 : 4;
        ns = tgt[0];
        nw = ns ? 2 : 4;
        al = ns ? (tgt & ~AW'(1)) : (tgt & ~AW'(3));
        @(negedge clk);
        pc_i = pc; target_i = tgt; cur_state_i = cur; start_i = 1'b1;
        e = '{addr: pc + 2*ow, size: cur ? 2'd1 : 2'd2, st: cur, seq: 1'b0, done: 1'b0, nxt: 'x};
        sb.push_back(e);
        e = '{addr: al, size: ns ? 2'd1 : 2'd2, st: ns, seq: 1'b1, done: 1'b0, nxt: 'x};
        sb.push_back(e);
        e = '{addr: al + nw, size: ns ? 2'd1 : 2'd2, st: ns, seq: 1'b1, done: 1'b1, nxt: al + 2*nw};
        sb.push_back(e);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            // R8: values offered while busy must not be used
            pc_i = ~pc; target_i = ~tgt; cur_state_i = ~cur;
        end
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (mreq_o) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 extra request cycle", addr_o, '0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(addr_o == e.addr, e.seq ? (e.done ? "R4 addr" : "R3 addr") : "R2 addr",
                        addr_o, e.addr);
                    chk(size_o == e.size && state_o == e.st, "R2/R3 size_state R7",
                        {size_o, state_o}, {e.size, e.st});
                    chk(seq_o == e.seq, "R3 seq", seq_o, e.seq);
                    chk(done_o == e.done, "R4 done", done_o, e.done);
                    chk(opfetch_o && !write_o, "R6 fetch read", {opfetch_o, write_o}, 2'b10);
                    if (e.done) chk(next_addr_o == e.nxt, "R5 next", next_addr_o, e.nxt);
                end
            end else begin
                chk(!opfetch_o && !done_o, "R6 idle flags", {opfetch_o, done_o}, 2'b00);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mreq_o && !opfetch_o && !seq_o && !done_o && !state_o, "R1 reset flags",
            {mreq_o, opfetch_o, seq_o, done_o, state_o}, '0);
        chk(addr_o == '0 && next_addr_o == '0, "R1 reset addr", addr_o | next_addr_o, '0);
        mon_on = 1'b1;
        run_bx(32'h0000_1000, 32'h0000_2001, 1'b0, 0);  // wide to compact
        run_bx(32'h0000_2006, 32'h0000_3000, 1'b1, 0);  // compact to wide
        run_bx(32'h0000_0100, 32'h0000_4002, 1'b0, 0);  // R7 wide target low bits cleared
        run_bx(32'h0000_0102, 32'h0000_5003, 1'b1, 0);  // R7 compact keeps bit 1
        run_bx(32'hFFFF_FFFC, 32'hFFFF_FFFF, 1'b0, 2);  // wrap, start held while busy (R8)
        run_bx(32'h0000_8000, 32'h0000_9001, 1'b0, 3);  // R8 start held into last cycle
        run_bx(32'h0000_A000, 32'h0000_B00A, 1'b1, 0);
        @(negedge clk);
        chk(sb.size() == 0, "R8 all expected cycles seen", sb.size(), 0);
        chk(next_addr_o == 32'h0000_B008 + 8, "R5 handoff held", next_addr_o, 32'h0000_B010);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule